// File: doc/BRIEF.md
# Serially Loaded Two-Layer Sigmoid Network

This block evaluates a tiny feedforward network: three unsigned 8-bit features enter a hidden layer of three neurons that work side by side, and the three 8-bit hidden activations feed one output neuron whose activation is the result. Every neuron forms a weighted sum of its inputs, without bias, and passes it through a saturating sigmoid held in a constant lookup table.

Pins are saved on the weight path. All twelve signed 8-bit coefficients (nine hidden, three output) come from a constant table inside the controller. They travel over one 8-bit serial path, one word per clock, through a chain of weight registers. Each request reloads the chain, and no neuron accumulates before the last word has settled. A single clock runs the controller and both layers.

The control interface is a plain start/busy/done handshake rather than a stream. A request is accepted only while idle. Nothing can stall the block: the result is held on `score` from its done pulse until the next one, and the caller reads it whenever it wants.

Top module: `nn_serial_net`

## Requirements
- R1: While reset is held and after its release, busy, done and score are all 0.
- R2: A start seen while idle captures feat0, feat1 and feat2 and raises busy in the next cycle. Later changes to the features do not affect that request.
- R3: Coefficient k (k = 0..11) is ((53*k + 19) mod 256) - 128, read as 8-bit two's complement. Hidden neuron n (n = 0..2) weights feature i with coefficient 3n+i. The output neuron weights hidden activation n with coefficient 9+n.
- R4: The coefficients are shifted in one per cycle for 12 cycles before any accumulation. done is seen 16 clock edges after the edge that accepted start.
- R5: A neuron's net input is the exact signed sum of its input-weight products. Inputs are unsigned and weights are signed. The sum is held in an 18-bit signed accumulator.
- R6: The table address is t = floor(net / 1024), clamped to [-32, 31]. With m = |t|, the activation is 128 + (127*(64m - m*m))/1024 for t >= 0 and 128 - (127*(64m - m*m))/1024 for t < 0, using integer division.
- R7: The output neuron applies R5 and R6 to the three hidden activations, and score is its activation.
- R8: done is high for exactly one cycle, in the cycle in which busy has fallen. score changes only together with done and holds afterwards.
- R9: A start seen while busy is ignored: the running result, its timing and the number of done pulses are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for controller and both layers |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an evaluation (accepted only while idle) |
| feat0 | input | 8 | Unsigned feature 0 |
| feat1 | input | 8 | Unsigned feature 1 |
| feat2 | input | 8 | Unsigned feature 2 |
| busy | output | 1 | High from acceptance until the result is delivered |
| done | output | 1 | One-cycle pulse marking a new score |
| score | output | 8 | Output neuron activation, held between pulses |

## Verification
The hardest situation to reach from the ports is a second start that lands in the middle of coefficient loading, with different feature values applied at the same moment. If the controller restarted or recaptured, the result would shift in both value and timing. The stimulus raises start again four cycles into loading and inverts all three features. The bench then checks that the original result still arrives after exactly 16 edges, with a single done pulse. Feature sets are also chosen so that hidden neurons drive the table address past both clamp limits, which reaches the saturated ends of the sigmoid.

// File: rtl/nn_pkg.sv
package nn_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_HACC,
    ST_HACT,
    ST_OACC,
    ST_FIN
  } nn_state_e;

  // Saturating quadratic squash: z is the clamped table address (signed),
  // half the clamp magnitude, amp the swing and mid the output at zero.
  function automatic int squash(int z, int half, int amp, int mid);
    int m;
    int q;
    m = (z < 0) ? -z : z;
    if (m > half) m = half;
    q = (amp * (2 * half * m - m * m)) / (half * half);
    return (z < 0) ? (mid - q) : (mid + q);
  endfunction

endpackage

// File: rtl/nn_weight_chain.sv
module nn_weight_chain #(
  parameter int WW    = 8,
  parameter int DEPTH = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift_en,
  input  logic [WW-1:0]         din,
  output logic [DEPTH*WW-1:0]   taps
);

  logic [WW-1:0] stage [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) stage[j] <= '0;
    end else if (shift_en) begin
      stage[0] <= din;
      for (int j = 1; j < DEPTH; j++) stage[j] <= stage[j-1];
    end
  end

  for (genvar j = 0; j < DEPTH; j++) begin : g_tap
    assign taps[j*WW +: WW] = stage[j];
  end

endmodule

// File: rtl/nn_neuron.sv
module nn_neuron #(
  parameter int NI    = 3,
  parameter int DW    = 8,
  parameter int WW    = 8,
  parameter int AW    = 18,
  parameter int SHIFT = 10,
  parameter int LAW   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              act_en,
  input  logic [NI*DW-1:0]  act_in,
  input  logic [NI*WW-1:0]  w_in,
  output logic [DW-1:0]     act_out
);

  localparam int LN   = 1 << LAW;
  localparam int HALF = LN / 2;
  localparam int MID  = 1 << (DW - 1);
  localparam int AMP  = MID - 1;
  localparam logic signed [AW-1:0] LO = AW'(-HALF);
  localparam logic signed [AW-1:0] HI = AW'(HALF - 1);

  typedef logic [DW-1:0] lut_t [LN];

  function automatic lut_t build_lut();
    lut_t t;
    for (int a = 0; a < LN; a++) t[a] = DW'(nn_pkg::squash(a - HALF, HALF, AMP, MID));
    return t;
  endfunction

  localparam lut_t LUT = build_lut();

  logic signed [AW-1:0] net_d;
  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] scaled;
  logic [LAW-1:0]       idx;
  logic [DW-1:0]        act_q;

  // Parallel multiply-accumulate over all inputs of this neuron.
  always_comb begin
    net_d = '0;
    for (int i = 0; i < NI; i++) begin
      net_d = net_d
            + $signed({{(AW-DW){1'b0}}, act_in[i*DW +: DW]})
            * $signed({{(AW-WW){w_in[i*WW+WW-1]}}, w_in[i*WW +: WW]});
    end
  end

  // Scale down and clamp into the table range.
  always_comb begin
    scaled = acc_q >>> SHIFT;
    if (scaled < LO)      idx = '0;
    else if (scaled > HI) idx = '1;
    else                  idx = LAW'(scaled - LO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      act_q <= '0;
    end else begin
      if (acc_en) acc_q <= net_d;
      if (act_en) act_q <= LUT[idx];
    end
  end

  assign act_out = act_q;

endmodule

// File: rtl/nn_ctrl.sv
module nn_ctrl #(
  parameter int NW      = 12,
  parameter int WW      = 8,
  parameter int ROM_MUL = 53,
  parameter int ROM_ADD = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          cap_en,
  output logic          shift_en,
  output logic [WW-1:0] rom_q,
  output logic          hacc_en,
  output logic          hact_en,
  output logic          oacc_en,
  output logic          oact_en
);
  import nn_pkg::*;

  localparam int CW = $clog2(NW);

  typedef logic [WW-1:0] rom_t [NW];

  // Offset by half the range so the stored word reads as value - 2^(WW-1).
  function automatic rom_t build_rom();
    rom_t r;
    for (int k = 0; k < NW; k++) r[k] = WW'(ROM_MUL * k + ROM_ADD + (1 << (WW - 1)));
    return r;
  endfunction

  localparam rom_t ROM = build_rom();

  nn_state_e     st;
  logic [CW-1:0] cnt;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (st == ST_FIN);
      unique case (st)
        ST_IDLE: if (start) begin
          st  <= ST_LOAD;
          cnt <= '0;
        end
        ST_LOAD: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(NW - 1)) st <= ST_HACC;
        end
        ST_HACC: st <= ST_HACT;
        ST_HACT: st <= ST_OACC;
        ST_OACC: st <= ST_FIN;
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st != ST_IDLE);
  assign done     = done_q;
  assign cap_en   = (st == ST_IDLE) && start;
  assign shift_en = (st == ST_LOAD);
  assign rom_q    = ROM[cnt];
  assign hacc_en  = (st == ST_HACC);
  assign hact_en  = (st == ST_HACT);
  assign oacc_en  = (st == ST_OACC);
  assign oact_en  = (st == ST_FIN);

endmodule

// File: rtl/nn_serial_net.sv
module nn_serial_net #(
  parameter int DW    = 8,
  parameter int WW    = 8,
  parameter int AW    = 18,
  parameter int SHIFT = 10,
  parameter int LAW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] feat0,
  input  logic [DW-1:0] feat1,
  input  logic [DW-1:0] feat2,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] score
);

  localparam int NI = 3;
  localparam int NH = 3;
  localparam int NW = NI * NH + NH;

  logic                 cap_en, shift_en;
  logic                 hacc_en, hact_en, oacc_en, oact_en;
  logic [WW-1:0]        rom_q;
  logic [NW*WW-1:0]     taps;
  logic [NI*DW-1:0]     feat_q;
  logic [NH-1:0][NI*WW-1:0] hid_w;
  logic [NH*WW-1:0]     out_w;
  logic [NH*DW-1:0]     hid_act;

  nn_ctrl #(.NW(NW), .WW(WW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .cap_en(cap_en),
    .shift_en(shift_en), .rom_q(rom_q),
    .hacc_en(hacc_en), .hact_en(hact_en),
    .oacc_en(oacc_en), .oact_en(oact_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      feat_q <= '0;
    else if (cap_en) feat_q <= {feat2, feat1, feat0};
  end

  nn_weight_chain #(.WW(WW), .DEPTH(NW)) u_chain (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
    .din(rom_q), .taps(taps)
  );

  // Coefficient k sits at chain stage NW-1-k once loading ends.
  for (genvar n = 0; n < NH; n++) begin : g_hid
    for (genvar i = 0; i < NI; i++) begin : g_w
      assign hid_w[n][i*WW +: WW] = taps[(NW-1-(n*NI+i))*WW +: WW];
    end

    nn_neuron #(.NI(NI), .DW(DW), .WW(WW), .AW(AW), .SHIFT(SHIFT), .LAW(LAW)) u_hid (
      .clk(clk), .rst_n(rst_n), .acc_en(hacc_en), .act_en(hact_en),
      .act_in(feat_q), .w_in(hid_w[n]), .act_out(hid_act[n*DW +: DW])
    );

    assign out_w[n*WW +: WW] = taps[(NW-1-(NI*NH+n))*WW +: WW];
  end

  nn_neuron #(.NI(NH), .DW(DW), .WW(WW), .AW(AW), .SHIFT(SHIFT), .LAW(LAW)) u_out (
    .clk(clk), .rst_n(rst_n), .acc_en(oacc_en), .act_en(oact_en),
    .act_in(hid_act), .w_in(out_w), .act_out(score)
  );

endmodule

// File: rtl/nn_serial_net_chk.sv
module nn_serial_net_chk #(
  parameter int NW = 12,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          shift_en,
  input logic          hacc_en,
  input logic [DW-1:0] score
);

  logic [7:0] shifts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                shifts <= '0;
    else if (!busy && start)   shifts <= '0;
    else if (shift_en)         shifts <= shifts + 8'd1;
  end

  // R2: an idle start begins a run
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R4: accumulation only after every coefficient has been shifted
  a_r4_load_complete: assert property (@(posedge clk) disable iff (!rst_n)
    hacc_en |-> (shifts == 8'(NW)));

  a_r4_no_late_shift: assert property (@(posedge clk) disable iff (!rst_n)
    hacc_en |-> !shift_en);

  // R8: single-cycle done, paired with busy falling
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r8_score_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(score) |-> done);

  // R9: a start during a run does not end or restart it
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

endmodule

bind nn_serial_net nn_serial_net_chk #(.NW(12), .DW(8)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .shift_en(shift_en), .hacc_en(hacc_en), .score(score)
);

// File: tb/nn_serial_net_test.sv
`timescale 1ns/1ps
module nn_serial_net_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] feat0 = '0, feat1 = '0, feat2 = '0;
  logic       busy, done;
  logic [7:0] score;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  nn_serial_net uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .feat0(feat0), .feat1(feat1), .feat2(feat2),
    .busy(busy), .done(done), .score(score)
  );

  // Reference model built from the requirement formulas.
  function automatic int coef(int k);                 // R3
    return ((53 * k + 19) % 256) - 128;
  endfunction

  function automatic int act(int net);                // R6
    int t, m, q;
    t = net >>> 10;
    if (t < -32) t = -32;
    if (t > 31)  t = 31;
    m = (t < 0) ? -t : t;
    q = (127 * (64 * m - m * m)) / 1024;
    return (t < 0) ? 128 - q : 128 + q;
  endfunction

  function automatic int model(int a, int b, int c);  // R5 R7
    int h[3];
    int net;
    for (int n = 0; n < 3; n++)
      h[n] = act(a * coef(3*n) + b * coef(3*n+1) + c * coef(3*n+2));
    net = h[0] * coef(9) + h[1] * coef(10) + h[2] * coef(11);
    return act(net);
  endfunction

  task automatic check(bit ok, string req, int actual, int expect_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expect_v);
    end
  endtask

  // Monitor: pops the scoreboard on every done pulse.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected done", score, -1);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(score == 8'(e), t, score, e);
      end
    end
  end

  // Driver: queue the expectation, request, and time the run.
  task automatic run(int a, int b, int c, string tag, bit poke);
    int n;
    int e;
    e = model(a, b, c);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    feat0 = 8'(a); feat1 = 8'(b); feat2 = 8'(c);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after accepted start", busy, 1);
    n = 0;
    do begin
      if (poke && n == 4) begin
        start = 1'b1;
        feat0 = ~feat0; feat1 = ~feat1; feat2 = ~feat2;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      n++;
    end while (!done && n < 100);
    start = 1'b0;
    check(n == 16, poke ? "R9 latency with start during load" : "R4 start-to-done latency", n, 16);
    check(busy == 1'b0, "R8 busy low with done", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R8 done lasts one cycle", done, 0);
    repeat (2) @(negedge clk);
    check(score == 8'(e), "R8 score held after done", score, e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(score == 8'd0, "R1 score in reset", score, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && score == 8'd0, "R1 idle after reset", {busy, done, score}, 0);

    run(0, 0, 0, "R3/R5/R6/R7 zero features", 1'b0);
    run(255, 255, 255, "R6 clamp low on hidden 0", 1'b0);
    run(255, 255, 0, "R6 clamp high on hidden 1", 1'b0);
    run(10, 200, 30, "R3/R5/R7 mixed features", 1'b0);
    run(0, 0, 255, "R5/R7 single feature", 1'b0);
    run(128, 64, 32, "R2/R9 start and feature change during load", 1'b1);
    run(77, 3, 190, "R7 back-to-back request", 1'b0);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 every request answered once", exp_q.size(), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R4 run did not complete actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule